// File: doc/BRIEF.md
# Power-Fail Reset Supervisor

This block turns digital comparator flags into the processor reset, an access-inhibit signal for the register file and a backup-supply select. The analog supply comparison is done elsewhere. The block sees only a power-good level, two voltage-ordering flags, an oscillator-running flag and a single-cycle enable from the 32.768 kHz timebase.

When power-good drops, the reset output falls on the next clock edge and register access is blocked. When power-good returns, the reset stays asserted for a fixed number of slow-clock ticks, 8192 by default, which is 250 ms. The count does not start until the oscillator reports that it is running. A short loss of power-good during the hold starts the count again from zero.

The backup select picks one of two switch-over points. The choice depends on whether the power-fail threshold sits above or below the battery voltage.

Top module: `pf_reset_supervisor`

## Requirements
- R1: When `vcc_ok_i` is sampled low on a clock edge, `rst_n_o` is low after that edge, whatever the previous state.
- R2: After the hold has started, `rst_n_o` goes high on the clock edge that samples the HOLD_TICKS-th high `tick_i` of the hold, provided `vcc_ok_i` stays high.
- R3: The hold starts on the first edge that samples both `vcc_ok_i` and `osc_run_i` high. `tick_i` pulses seen before that edge are not counted.
- R4: If `vcc_ok_i` is sampled low during the hold, the hold is abandoned. It restarts from zero ticks once R3 is met again.
- R5: `osc_run_i` going low after the hold has started has no effect on the hold or on the release time.
- R6: `access_block_o` is the value of `!vcc_ok_i` sampled on the previous clock edge.
- R7: `use_backup_o` is registered. When `vpf_above_bkup_i` is 1, it equals the previous-edge value of `!vcc_above_bkup_i`. When `vpf_above_bkup_i` is 0, it equals the previous-edge value of `!vcc_ok_i`.
- R8: While `rst_ni` is low, `rst_n_o` is 0, `access_block_o` is 1 and `use_backup_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vcc_ok_i | input | 1 | Supply above the power-fail threshold |
| vcc_above_bkup_i | input | 1 | Supply above the battery voltage |
| vpf_above_bkup_i | input | 1 | Power-fail threshold above the battery voltage |
| osc_run_i | input | 1 | Slow oscillator is running |
| tick_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rst_n_o | output | 1 | Processor reset, active low (low level drives the open-drain pad) |
| access_block_o | output | 1 | Inhibits register access from the serial interface |
| use_backup_o | output | 1 | Selects the backup supply |

## Verification
The bench lets slow ticks run while the oscillator flag is held low. A design that counted those ticks would release reset early.

It drops power-good partway through a hold. A design that only paused the counter would then release well before a full hold after recovery.

It clears the oscillator flag partway through a hold. A design that restarted or froze the hold there would release late.

It steps the backup-select inputs through every combination of threshold ordering. A design with the two comparison points swapped would select the wrong supply in half of those cases.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    PF_WAIT = 2'd0,
    PF_HOLD = 2'd1,
    PF_RUN  = 2'd2
  } pf_state_e;
endpackage

// File: rtl/pfr_hold_cnt.sv
module pfr_hold_cnt #(
  parameter int unsigned HOLD_TICKS = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int unsigned CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r4_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pfr_seq.sv
module pfr_seq
  import pfr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic osc_run_i,
  input  logic tick_i,
  input  logic last_i,
  output logic in_hold_o,
  output logic released_o
);
  pf_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!vcc_ok_i) state_d = PF_WAIT;
    else begin
      case (state_q)
        PF_WAIT: if (osc_run_i)        state_d = PF_HOLD;
        PF_HOLD: if (tick_i && last_i) state_d = PF_RUN;
        PF_RUN:                        state_d = PF_RUN;
        default:                       state_d = PF_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PF_WAIT;
    else         state_q <= state_d;
  end

  assign in_hold_o  = (state_q == PF_HOLD);
  assign released_o = (state_q == PF_RUN);

  a_r3_hold_needs_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_hold_o) |-> $past(osc_run_i && vcc_ok_i));
  a_r2_release_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(released_o) |-> $past(tick_i && last_i));
endmodule

// File: rtl/pfr_bkup_sel.sv
module pfr_bkup_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic vcc_above_bkup_i,
  input  logic vpf_above_bkup_i,
  output logic use_backup_o
);
  logic sel_d;

  // threshold above battery: switch at battery level, else at threshold
  assign sel_d = vpf_above_bkup_i ? !vcc_above_bkup_i : !vcc_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) use_backup_o <= 1'b0;
    else         use_backup_o <= sel_d;
  end

  a_r7_bkup_high_vpf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpf_above_bkup_i && !vcc_above_bkup_i) |=> use_backup_o);
  a_r7_bkup_low_vpf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpf_above_bkup_i && vcc_ok_i) |=> !use_backup_o);
endmodule

// File: rtl/pf_reset_supervisor.sv
module pf_reset_supervisor #(
  parameter int unsigned HOLD_TICKS = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic vcc_above_bkup_i,
  input  logic vpf_above_bkup_i,
  input  logic osc_run_i,
  input  logic tick_i,
  output logic rst_n_o,
  output logic access_block_o,
  output logic use_backup_o
);
  logic in_hold, released, last;

  pfr_hold_cnt #(.HOLD_TICKS(HOLD_TICKS)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_hold),
    .tick_i (tick_i),
    .last_o (last)
  );

  pfr_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vcc_ok_i   (vcc_ok_i),
    .osc_run_i  (osc_run_i),
    .tick_i     (tick_i),
    .last_i     (last),
    .in_hold_o  (in_hold),
    .released_o (released)
  );

  pfr_bkup_sel i_bkup (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .vcc_ok_i         (vcc_ok_i),
    .vcc_above_bkup_i (vcc_above_bkup_i),
    .vpf_above_bkup_i (vpf_above_bkup_i),
    .use_backup_o     (use_backup_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) access_block_o <= 1'b1;
    else         access_block_o <= !vcc_ok_i;
  end

  assign rst_n_o = released;

  a_r1_fail_asserts_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |=> !rst_n_o);
  a_r6_block_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |=> access_block_o);
  a_r6_release_unblocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_n_o |-> !access_block_o);
endmodule

// File: tb/test_pf_reset_supervisor.sv
module test_pf_reset_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 8192;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vcc_ok = 1'b0, vcc_above = 1'b0, vpf_above = 1'b0, osc_run = 1'b0, tick = 1'b0;
  logic tick_run = 1'b0;
  logic rst_n, blk, bkup;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit m_up = 0, m_armed = 0, m_blk = 1, m_bkup = 0;
  int m_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_reset_supervisor #(.HOLD_TICKS(HOLD)) i_pf_reset_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .vcc_ok_i(vcc_ok), .vcc_above_bkup_i(vcc_above),
    .vpf_above_bkup_i(vpf_above), .osc_run_i(osc_run), .tick_i(tick),
    .rst_n_o(rst_n), .access_block_o(blk), .use_backup_o(bkup));

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_up = 0; m_armed = 0; m_n = 0; m_blk = 1; m_bkup = 0;
    end else begin
      m_blk = !vcc_ok;
      m_bkup = vpf_above ? !vcc_above : !vcc_ok;
      if (!vcc_ok) begin
        m_up = 0; m_armed = 0; m_n = 0;
      end else if (!m_up) begin
        if (!m_armed) begin
          if (osc_run) begin m_armed = 1; m_n = 0; end
        end else if (tick) begin
          m_n = m_n + 1;
          if (m_n == HOLD) begin m_up = 1; m_armed = 0; end
        end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      check("R2 rst_n", rst_n, m_up);
      check("R6 access_block", blk, m_blk);
      check("R7 use_backup", bkup, m_bkup);
    end
    if (cyc > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  always @(negedge clk) tick <= tick_run ? ~tick : 1'b0;

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns negedges until rst_n rises
  task automatic wait_release(output int n);
    n = 0;
    while (rst_n !== 1'b1 && n < 3*HOLD) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    cycles(3);
    check("R8 reset rst_n", rst_n, 1'b0);
    check("R8 reset access_block", blk, 1'b1);
    check("R8 reset use_backup", bkup, 1'b0);
    rst_ni = 1'b1;
    tick_run = 1'b1;
    cycles(2);

    // R2: plain power-up with oscillator running
    vcc_ok = 1; vcc_above = 1; osc_run = 1;
    wait_release(n);
    check_range("R2 hold length", n, 2*HOLD - 1, 2*HOLD + 2);
    check("R2 released", rst_n, 1'b1);

    // R1: supply drop
    vcc_ok = 0; vcc_above = 0; osc_run = 0;
    cycles(1);
    check("R1 rst low after drop", rst_n, 1'b0);
    check("R6 blocked after drop", blk, 1'b1);
    cycles(5);

    // R3: supply back but oscillator stopped; ticks must not count
    vcc_ok = 1; vcc_above = 1;
    cycles(400);
    check("R3 still held with osc off", rst_n, 1'b0);
    osc_run = 1;
    wait_release(n);
    check_range("R3 hold from osc start", n, 2*HOLD - 1, 2*HOLD + 2);

    // R4: glitch during hold restarts count
    vcc_ok = 0; cycles(3); vcc_ok = 1;
    cycles(HOLD);
    vcc_ok = 0; cycles(1);
    check("R1 rst low on glitch", rst_n, 1'b0);
    vcc_ok = 1;
    wait_release(n);
    check_range("R4 full hold after glitch", n, 2*HOLD - 1, 2*HOLD + 2);

    // R5: oscillator flag dropping mid-hold is ignored
    vcc_ok = 0; cycles(3); vcc_ok = 1;
    cycles(100);
    osc_run = 0;
    wait_release(n);
    check_range("R5 release unaffected by osc", n, 2*HOLD - 101, 2*HOLD - 97);
    osc_run = 1;

    // R7: backup select combinations
    for (int k = 0; k < 8; k++) begin
      vpf_above = k[0]; vcc_above = k[1]; vcc_ok = k[2];
      cycles(1);
      check("R7 backup select", bkup, vpf_above ? !vcc_above : !vcc_ok);
      check("R6 access follows vcc_ok", blk, !vcc_ok);
    end
    cycles(4);
    finish_run();
  end
endmodule